// File: doc/BRIEF.md
# Switched-Capacitor Sampler Readout Sequencer

This block drives the control pins of a switched-capacitor waveform sampling chip through a full region-of-interest acquisition cycle. After reset it loads the chip's configuration register and then its write shift register. Each load is eight bits sent over a serial data and serial clock pair, with a 4-bit address bus selecting the target register. The block then enables sampling with write active and waits for a trigger.

On a trigger rising edge the sequencer stops writing into the sampling cells but leaves the sampling enable high. It then strobes the read-shift-register load line for a fixed number of system cycles and switches the address bus to the all-channel readout selection. Next it issues a programmed number of serial clock pulses. During these pulses it shifts the chip's serial output into a stop-position register. After the last pulse it presents the stop position with a one-cycle done flag and re-arms sampling. The two configuration registers are not loaded again.

Each serial bit takes two system cycles: one with the clock low and one with the clock high. Both the serial data and the address bus stay steady across the pair.

Top module: `capsamp_seq`

## Requirements
- R1: While reset is asserted, and in the cycle it is released, den, dwr, rsload, sclk and done are 0 and stop_pos is 0.
- R2: The first load after reset gives exactly 8 sclk pulses with addr = 4'b1100. sdata carries CFG_WORD most significant bit first, valid while sclk is high. addr and sdata do not change during a high sclk cycle.
- R3: The second load follows at once. It gives exactly 8 sclk pulses with addr = 4'b1101 and WSR_WORD sent most significant bit first.
- R4: After both loads, den and dwr are both 1 and stay so, with no sclk or rsload activity, until a rising edge on trig_in. trig_in passes through two synchronising flip-flops. dwr is never 1 while den is 0.
- R5: On a synchronised trig_in rising edge seen while armed, dwr falls and den stays 1. trig_in edges at any other time are ignored. Such an edge never causes a later readout, so dwr stays high after re-arming.
- R6: rsload is high for exactly LOAD_CYC consecutive cycles. It rises one cycle after dwr falls. LOAD_CYC times the clock period is at least 10 ns.
- R7: After rsload falls, addr = 4'b1001 and exactly n sclk pulses follow. n is the value of n_clk one cycle after rsload falls. With n = 0 there are no pulses.
- R8: sr_out is sampled in each high sclk cycle of the readout and shifted into stop_pos most significant bit first. stop_pos holds the last STOP_BITS bits of this readout only. If fewer bits were clocked, it is zero-filled at the top.
- R9: done is high for exactly one cycle after the last readout pulse, or after the address switch when n = 0. stop_pos is valid in that cycle and holds until the next done.
- R10: In the cycle after done, dwr and den are 1 again. No further configuration pulses are issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | 1 | Asynchronous trigger, acted on at its rising edge |
| sr_out | input | 1 | Serial stop-position output of the sampling chip |
| n_clk | input | CNT_W | Number of readout serial clock pulses |
| addr | output | 4 | Chip register/readout address |
| sdata | output | 1 | Serial configuration data |
| sclk | output | 1 | Serial clock |
| den | output | 1 | Sampling enable |
| dwr | output | 1 | Sampling write enable |
| rsload | output | 1 | Read-shift-register load strobe |
| done | output | 1 | One-cycle readout-complete flag |
| stop_pos | output | STOP_BITS | Captured stop position |

## Verification
Assertions check the following on every cycle:
- write-enable only under sampling enable;
- the gap cycle between the write-enable drop and the load strobe;
- steady address and data while the serial clock is high;
- the readout address under every readout pulse;
- the single-cycle done flag.

Only the bench scenarios can show the following:
- the serial bit order and pulse counts of the two loads;
- the exact load-strobe width;
- the pulse count per programmed n, including n = 0;
- the captured stop value for several serial patterns;
- that triggers during configuration or readout are ignored and that re-arming skips reconfiguration.

// File: rtl/capsamp_seq.sv
module capsamp_seq #(
  parameter int               CFG_BITS  = 8,
  parameter logic [CFG_BITS-1:0] CFG_WORD = 8'hFF,
  parameter logic [CFG_BITS-1:0] WSR_WORD = 8'hFF,
  parameter logic [3:0]       ADDR_CFG  = 4'b1100,
  parameter logic [3:0]       ADDR_WSR  = 4'b1101,
  parameter logic [3:0]       ADDR_READ = 4'b1001,
  parameter int               LOAD_CYC  = 4,
  parameter int               STOP_BITS = 10,
  parameter int               CNT_W     = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 trig_in,
  input  logic                 sr_out,
  input  logic [CNT_W-1:0]     n_clk,
  output logic [3:0]           addr,
  output logic                 sdata,
  output logic                 sclk,
  output logic                 den,
  output logic                 dwr,
  output logic                 rsload,
  output logic                 done,
  output logic [STOP_BITS-1:0] stop_pos
);

  localparam int BIT_W = (CFG_BITS > 1) ? $clog2(CFG_BITS) : 1;

  typedef enum logic [2:0] {
    S_CFG, S_WSR, S_ARM, S_STOP, S_LOAD, S_RADDR, S_READ, S_DONE
  } st_t;

  st_t                  st;
  logic                 ph;
  logic [CNT_W-1:0]     cnt;
  logic [CNT_W-1:0]     n_lat;
  logic [2:0]           tsync;
  logic [STOP_BITS-1:0] stop_sh;

  wire trig_rise = tsync[1] & ~tsync[2];
  wire last_bit  = (cnt == CNT_W'(CFG_BITS - 1));
  wire last_ld   = (cnt == CNT_W'(LOAD_CYC - 1));
  wire last_rd   = (cnt == n_lat - CNT_W'(1));
  wire shifting  = (st == S_CFG) || (st == S_WSR) || (st == S_READ);
  wire [BIT_W-1:0] bidx = BIT_W'(CFG_BITS - 1) - cnt[BIT_W-1:0];
  wire [STOP_BITS-1:0] stop_nx = {stop_sh[STOP_BITS-2:0], sr_out};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_CFG;
      ph       <= 1'b0;
      cnt      <= '0;
      n_lat    <= '0;
      tsync    <= '0;
      stop_sh  <= '0;
      stop_pos <= '0;
    end else begin
      tsync <= {tsync[1:0], trig_in};
      case (st)
        S_CFG, S_WSR: begin
          ph <= ~ph;
          if (ph) begin
            if (last_bit) begin
              cnt <= '0;
              st  <= (st == S_CFG) ? S_WSR : S_ARM;
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
        end
        S_ARM: if (trig_rise) st <= S_STOP;
        S_STOP: begin
          cnt <= '0;
          st  <= S_LOAD;
        end
        S_LOAD: begin
          if (last_ld) begin
            cnt <= '0;
            st  <= S_RADDR;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        S_RADDR: begin
          n_lat   <= n_clk;
          stop_sh <= '0;
          if (n_clk == '0) begin
            stop_pos <= '0;
            st       <= S_DONE;
          end else begin
            st <= S_READ;
          end
        end
        S_READ: begin
          ph <= ~ph;
          if (ph) begin
            stop_sh <= stop_nx;
            if (last_rd) begin
              cnt      <= '0;
              stop_pos <= stop_nx;
              st       <= S_DONE;
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
        end
        default: st <= S_ARM;
      endcase
    end
  end

  assign sclk   = ph & shifting;
  assign den    = (st != S_CFG) && (st != S_WSR);
  assign dwr    = (st == S_ARM);
  assign rsload = (st == S_LOAD);
  assign done   = (st == S_DONE);
  assign sdata  = (st == S_CFG) ? CFG_WORD[bidx] :
                  (st == S_WSR) ? WSR_WORD[bidx] : 1'b0;

  always_comb begin
    case (st)
      S_CFG:                  addr = ADDR_CFG;
      S_ARM, S_STOP, S_LOAD,
      S_WSR:                  addr = ADDR_WSR;
      default:                addr = ADDR_READ;
    endcase
  end

  // R4
  wr_under_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dwr |-> den);

  // R5
  stop_keeps_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dwr) |-> (den && !rsload));

  // R6
  load_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsload) |-> $past(!dwr && den));

  // R2
  serial_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> ($stable(sdata) && $stable(addr)));

  // R7
  read_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && den) |-> (addr == ADDR_READ));

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/test_capsamp_seq.sv
module test_capsamp_seq;
  localparam int          CNT_W = 12;
  localparam int          SB    = 10;
  localparam int          LDC   = 3;
  localparam int          TCLK  = 4;
  localparam logic [7:0]  CW    = 8'hA5;
  localparam logic [7:0]  WW    = 8'h3C;
  localparam int          NV    = 6;
  localparam logic [11:0] VN [NV] = '{12'd10, 12'd1, 12'd13, 12'd16, 12'd0, 12'd3};
  localparam logic [15:0] VP [NV] = '{16'hB400, 16'h8000, 16'hA5C3, 16'hFFFF, 16'hFFFF, 16'h6000};

  logic clk = 1'b0, rst_n = 1'b0, trig = 1'b0, sro = 1'b0;
  logic [CNT_W-1:0] n_clk = '0;
  logic [3:0] addr;
  logic sdata, sclk, den, dwr, rsload, done;
  logic [SB-1:0] stop_pos;

  always #(TCLK/2) clk = ~clk;

  capsamp_seq #(.CFG_WORD(CW), .WSR_WORD(WW), .LOAD_CYC(LDC),
                .STOP_BITS(SB), .CNT_W(CNT_W)) i_capsamp_seq (
    .clk(clk), .rst_n(rst_n), .trig_in(trig), .sr_out(sro), .n_clk(n_clk),
    .addr(addr), .sdata(sdata), .sclk(sclk), .den(den), .dwr(dwr),
    .rsload(rsload), .done(done), .stop_pos(stop_pos));

  int passed = 0, total = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (ok) passed++;
    else $display("FAIL %s: actual %0d expected %0d", req, act, exp);
  endtask

  function automatic logic pbit(input logic [15:0] p, input int k);
    return (k < 16) ? p[15-k] : 1'b0;
  endfunction

  function automatic logic [SB-1:0] exp_stop(input logic [15:0] p, input int n);
    logic [SB-1:0] a = '0;
    for (int k = 0; k < n; k++) a = {a[SB-2:0], pbit(p, k)};
    return a;
  endfunction

  int cfg_n = 0, wsr_n = 0, rd_n = 0, stray_n = 0, rs_len = 0, rs_last = 0, done_n = 0;
  logic [7:0] cfg_got = '0, wsr_got = '0;
  logic [SB-1:0] stop_seen = '0;
  logic [15:0] pat = '0;
  bit gap_ok = 0;
  logic prev_sclk = 0, prev_rs = 0, prev_dwr = 0;

  always @(negedge clk) begin
    if (sclk && !prev_sclk) begin
      if (addr == 4'b1100) begin cfg_got = {cfg_got[6:0], sdata}; cfg_n++; end
      else if (addr == 4'b1101) begin wsr_got = {wsr_got[6:0], sdata}; wsr_n++; end
      else if (addr == 4'b1001) rd_n++;
      else stray_n++;
    end
    if (rsload) rs_len++;
    else if (prev_rs) begin rs_last = rs_len; rs_len = 0; end
    if (rsload && !prev_rs) gap_ok = !prev_dwr && !dwr && den;
    if (done) begin done_n++; stop_seen = stop_pos; end
    if (!sclk) sro = pbit(pat, rd_n);
    prev_sclk = sclk; prev_rs = rsload; prev_dwr = dwr;
  end

  task automatic wait_done(input int limit);
    for (int c = 0; c < limit && done_n == 0; c++) @(negedge clk);
  endtask

  task automatic hold_armed(input int cycles, input string req);
    int bad = 0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      if (!dwr || !den || rsload || sclk) bad++;
    end
    chk(bad == 0, req, bad, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!den && !dwr && !rsload && !sclk && !done, "R1", {den, dwr, rsload, sclk, done}, 0);
    chk(stop_pos == '0, "R1", stop_pos, 0);
    rst_n = 1'b1;
    chk(!den && !dwr && !rsload && !done, "R1", {den, dwr, rsload, done}, 0);
    repeat (4) @(negedge clk);
    trig = 1'b1;
    repeat (3) @(negedge clk);
    trig = 1'b0;
    for (int c = 0; c < 100 && !dwr; c++) @(negedge clk);
    chk(cfg_n == 8, "R2", cfg_n, 8);
    chk(cfg_got == CW, "R2", cfg_got, CW);
    chk(wsr_n == 8, "R3", wsr_n, 8);
    chk(wsr_got == WW, "R3", wsr_got, WW);
    chk(den && dwr && stray_n == 0, "R4", {den, dwr}, 3);
    // R5 trigger during configuration ignored
    hold_armed(20, "R5");
    chk(LDC * TCLK >= 10, "R6", LDC * TCLK, 10);

    for (int i = 0; i < NV; i++) begin
      n_clk = VN[i]; pat = VP[i];
      rd_n = 0; done_n = 0; gap_ok = 0; rs_last = 0;
      trig = 1'b1;
      repeat (4) @(negedge clk);
      trig = 1'b0;
      wait_done(300);
      chk(done_n == 1, "R9", done_n, 1);
      chk(gap_ok, "R5", gap_ok, 1);
      chk(rs_last == LDC, "R6", rs_last, LDC);
      chk(rd_n == int'(VN[i]), "R7", rd_n, VN[i]);
      chk(stop_seen == exp_stop(VP[i], VN[i]), "R8", stop_seen, exp_stop(VP[i], VN[i]));
      @(negedge clk);
      chk(!done && dwr && den, "R10", {done, dwr, den}, 3);
      chk(cfg_n == 8 && wsr_n == 8, "R10", cfg_n + wsr_n, 16);
      repeat (5) @(negedge clk);
      chk(stop_pos == stop_seen, "R9", stop_pos, stop_seen);
    end

    // R5 trigger during readout ignored; R8 with n beyond pattern length
    n_clk = 12'd40; pat = 16'hC3A5;
    rd_n = 0; done_n = 0;
    trig = 1'b1;
    repeat (4) @(negedge clk);
    trig = 1'b0;
    repeat (20) @(negedge clk);
    trig = 1'b1;
    repeat (3) @(negedge clk);
    trig = 1'b0;
    wait_done(300);
    chk(rd_n == 40, "R7", rd_n, 40);
    chk(stop_seen == exp_stop(16'hC3A5, 40), "R8", stop_seen, exp_stop(16'hC3A5, 40));
    @(negedge clk);
    hold_armed(30, "R5");
    chk(stray_n == 0, "R4", stray_n, 0);

    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end
endmodule